// File: doc/BRIEF.md
# Multi-Format Serial Audio Frame Transmitter

The block is a master-side serial audio port. It divides the system clock down to a bit clock and drives a frame sync. It shifts stereo sample pairs out on one data line. One frame carries a left word and then a right word. The word length is 16, 24 or 32 bits. The sync waveform is built from three controls: its polarity, whether it leads the frame by one bit, and whether it lasts one bit or one whole word. These three controls cover four framing formats. The data always changes on the falling bit clock edge, so the far end samples it on the rising edge.

A receive path deserialises an incoming data line. It uses the bit clock and frame sync that the transmitter generates, not timing of its own. Both paths share one enable rule: the transmit engine runs only while the receive side is enabled. Software can therefore enable the receiver first and disable the transmitter first.

A stereo pair is offered on a valid/ready handshake, and the block takes it at each frame boundary. If no pair is offered, the frame is sent as zeros and a sticky underrun flag is raised.

Top module: `aud_frame_tx`

## Requirements
- R1: While running, `bclk` toggles every HALF_DIV system clocks, so consecutive falling edges are 2*HALF_DIV clocks apart. While stopped, `bclk` holds at 1. The block runs when `tx_en && rx_en`.
- R2: Each frame sends the left word and then the right word, MSB first. The word length W is set by `width_sel`: 0 gives 16 bits, 1 gives 24 bits, 2 or 3 give 32 bits. W is taken from the low W bits of `smp_left` and `smp_right`. `sd_out` changes only in the cycle where `bclk` falls.
- R3: `fmt_sel`=0 (I2S): `fsync` is low for one word length and high for the other. It changes one bit period early, together with the last bit of the previous word, so it is low from the last bit of the right word through the next-to-last bit of the left word.
- R4: `fmt_sel`=1 (left-justified): `fsync` is high exactly while the left word bits are on `sd_out`.
- R5: `fmt_sel`=2 (DSP mode A): `fsync` is high for one bit period, during the last bit of the previous frame.
- R6: `fmt_sel`=3 (DSP mode B): `fsync` is high for one bit period, during the first left bit.
- R7: `smp_ready` is a one-cycle pulse in the cycle just before the `bclk` fall that presents bit 0 of a frame. The pair on the inputs in that cycle is taken if `smp_valid` is 1.
- R8: If `smp_valid` is 0 at an `smp_ready` pulse, both words of that frame are sent as zeros and `urun` is set. `urun` stays at 1 until `urun_clr` is 1. A set in the same cycle wins over a clear.
- R9: The receiver samples `sd_in` on each rising `bclk` edge, using the transmitter's framing. After the last right bit it pulses `rx_valid` for one cycle, with both words right-aligned and zero-extended on `rx_left` and `rx_right`.
- R10: While stopped, `fsync` is at its inactive level (1 for format 0, otherwise 0) and `sd_out` is 0. Dropping `rx_en` stops the transmitter even if `tx_en` stays at 1.
- R11: The first bit period after a start is a lead-in at the last position of a frame. It carries data 0 and the sync level for that position, so early-sync formats show their early edge before the first frame.
- R12: `fmt_sel` and `width_sel` are taken only while stopped. Changes made while running do not affect the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable; also gates the transmitter |
| fmt_sel | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 DSP A, 3 DSP B |
| width_sel | input | 2 | Word length: 0 = 16, 1 = 24, 2/3 = 32 |
| smp_valid | input | 1 | Stereo pair offered |
| smp_ready | output | 1 | Pair taken this cycle |
| smp_left | input | SAMPLE_W | Left sample, right-aligned |
| smp_right | input | SAMPLE_W | Right sample, right-aligned |
| urun_clr | input | 1 | Clears the underrun flag |
| urun | output | 1 | Sticky underrun flag |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Generated frame sync |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| rx_left | output | SAMPLE_W | Received left word, right-aligned |
| rx_right | output | SAMPLE_W | Received right word, right-aligned |
| rx_valid | output | 1 | Received pair valid strobe |

## Verification
The assertions assume a few things about the inputs:
- `fmt_sel` and `width_sel` are steady for the cycle before a start.
- `urun_clr` is a short pulse.
- `sd_in` is only meaningful when it follows the block's own bit clock.

The stimulus respects these assumptions:
- Configuration is set with both enables low, and `rx_en` is raised before `tx_en`.
- `sd_in` is looped back from `sd_out`.
- New stimulus pairs are applied one cycle after a `smp_ready` pulse, so the pair being taken is never changed under the block.

Random formats, widths and valid patterns are mixed with directed runs for underrun, for a configuration change while running, and for a receiver-first stop.

// File: rtl/aud_frame_pkg.sv
package aud_frame_pkg;

   typedef enum logic [1:0] {
      FMT_I2S        = 2'd0,
      FMT_LEFT       = 2'd1,
      FMT_PULSE_LEAD = 2'd2,
      FMT_PULSE_ON   = 2'd3
   } frame_fmt_e;

   typedef struct packed {
      logic act_low;   // sync active level is 0
      logic early;     // sync leads frame by one bit
      logic one_bit;   // sync lasts one bit instead of one word
   } sync_ctl_t;

   function automatic sync_ctl_t decode_fmt(frame_fmt_e f);
      sync_ctl_t c;
      c.act_low = (f == FMT_I2S);
      c.early   = (f == FMT_I2S) || (f == FMT_PULSE_LEAD);
      c.one_bit = (f == FMT_PULSE_LEAD) || (f == FMT_PULSE_ON);
      return c;
   endfunction

   function automatic int unsigned word_bits(logic [1:0] ws);
      case (ws)
         2'd0:    return 16;
         2'd1:    return 24;
         default: return 32;
      endcase
   endfunction

endpackage

// File: rtl/aud_sclk_div.sv
module aud_sclk_div #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic bclk,
   output logic fall_evt,
   output logic rise_evt
);

   logic terminal;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign terminal = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (!run || cnt == CW'(HALF_DIV - 1))
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
         assign terminal = (cnt == CW'(HALF_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bclk <= 1'b1;
      else if (!run)
         bclk <= 1'b1;
      else if (terminal)
         bclk <= ~bclk;
   end

   assign fall_evt = run && terminal && bclk;
   assign rise_evt = run && terminal && !bclk;

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> bclk);

   assert_fall_lands_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> (!bclk || !run));

endmodule

// File: rtl/aud_frame_seq.sv
module aud_frame_seq
   import aud_frame_pkg::*;
#(
   parameter int SAMPLE_W = 32,
   localparam int POS_W = $clog2(2 * SAMPLE_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fall_evt,
   input  logic             rise_evt,
   input  sync_ctl_t        ctl,
   input  logic [POS_W-1:0] wbits,
   output logic             fsync,
   output logic             frame_start,
   output logic             right_start,
   output logic             rx_bit_en,
   output logic             rx_word_start,
   output logic             rx_end_left,
   output logic             rx_end_right
);

   logic [POS_W-1:0] pos;
   logic [POS_W-1:0] nxt;
   logic [POS_W-1:0] last;
   logic             started;
   logic             seen;
   logic             sync_on;

   assign last = (wbits << 1) - POS_W'(1);

   always_comb begin
      if (!started)
         nxt = last;                 // lead-in position
      else if (pos == last)
         nxt = '0;
      else
         nxt = pos + 1'b1;
   end

   // sync shape from the three controls
   always_comb begin
      if (ctl.one_bit)
         sync_on = ctl.early ? (nxt == last) : (nxt == '0);
      else if (ctl.early)
         sync_on = (nxt == last) || (nxt < wbits - POS_W'(1));
      else
         sync_on = (nxt < wbits);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos     <= '0;
         started <= 1'b0;
         seen    <= 1'b0;
         fsync   <= 1'b0;
      end else if (!run) begin
         pos     <= '0;
         started <= 1'b0;
         seen    <= 1'b0;
         fsync   <= ctl.act_low;
      end else if (fall_evt) begin
         pos     <= nxt;
         started <= 1'b1;
         fsync   <= sync_on ^ ctl.act_low;
         if (nxt == '0)
            seen <= 1'b1;
      end
   end

   assign frame_start   = fall_evt && started && (nxt == '0);
   assign right_start   = fall_evt && started && (nxt == wbits);
   assign rx_bit_en     = rise_evt && seen;
   assign rx_word_start = (pos == '0) || (pos == wbits);
   assign rx_end_left   = rx_bit_en && (pos == wbits - POS_W'(1));
   assign rx_end_right  = rx_bit_en && (pos == last);

   assert_sync_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$past(fall_evt) |-> $stable(fsync));

   assert_pos_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (pos <= last));

endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift #(
   parameter int SAMPLE_W = 32,
   localparam int POS_W = $clog2(2 * SAMPLE_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                fall_evt,
   input  logic                frame_start,
   input  logic                right_start,
   input  logic [POS_W-1:0]    wbits,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                urun_clr,
   output logic                smp_ready,
   output logic                sd,
   output logic                urun
);

   logic [SAMPLE_W-1:0] shreg;
   logic [SAMPLE_W-1:0] hold;
   int unsigned         lshift;

   assign lshift    = SAMPLE_W - int'(wbits);
   assign smp_ready = frame_start;
   assign sd        = shreg[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         hold  <= '0;
         urun  <= 1'b0;
      end else begin
         if (!run) begin
            shreg <= '0;
            hold  <= '0;
         end else if (frame_start) begin
            if (smp_valid) begin
               shreg <= smp_left << lshift;
               hold  <= smp_right << lshift;
            end else begin
               shreg <= '0;
               hold  <= '0;
            end
         end else if (right_start) begin
            shreg <= hold;
         end else if (fall_evt) begin
            shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
         end

         if (frame_start && !smp_valid)
            urun <= 1'b1;
         else if (urun_clr)
            urun <= 1'b0;
      end
   end

   assert_urun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      urun && !urun_clr |=> urun);

   assert_urun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready && !smp_valid |=> urun);

endmodule

// File: rtl/aud_rx_cap.sv
module aud_rx_cap #(
   parameter int SAMPLE_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_en,
   input  logic                word_start,
   input  logic                end_left,
   input  logic                end_right,
   input  logic                sd_in,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid
);

   logic [SAMPLE_W-1:0] acc;
   logic [SAMPLE_W-1:0] acc_nxt;

   assign acc_nxt = word_start ? {{(SAMPLE_W-1){1'b0}}, sd_in}
                               : {acc[SAMPLE_W-2:0], sd_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rx_left  <= '0;
         rx_right <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (bit_en)
            acc <= acc_nxt;
         if (end_left)
            rx_left <= acc_nxt;
         if (end_right) begin
            rx_right <= acc_nxt;
            rx_valid <= 1'b1;
         end
      end
   end

   assert_rx_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

// File: rtl/aud_frame_tx.sv
module aud_frame_tx
   import aud_frame_pkg::*;
#(
   parameter int SAMPLE_W = 32,
   parameter int HALF_DIV = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tx_en,
   input  logic                rx_en,
   input  logic [1:0]          fmt_sel,
   input  logic [1:0]          width_sel,
   input  logic                smp_valid,
   output logic                smp_ready,
   input  logic [SAMPLE_W-1:0] smp_left,
   input  logic [SAMPLE_W-1:0] smp_right,
   input  logic                urun_clr,
   output logic                urun,
   output logic                bclk,
   output logic                fsync,
   output logic                sd_out,
   input  logic                sd_in,
   output logic [SAMPLE_W-1:0] rx_left,
   output logic [SAMPLE_W-1:0] rx_right,
   output logic                rx_valid
);

   localparam int POS_W = $clog2(2 * SAMPLE_W);

   generate
      if (SAMPLE_W < 32) begin : g_bad_width
         $error("SAMPLE_W must hold a 32-bit word");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
   endgenerate

   logic             run;
   frame_fmt_e       cfg_fmt;
   logic [1:0]       cfg_ws;
   sync_ctl_t        ctl;
   logic [POS_W-1:0] wbits;
   logic             fall_evt, rise_evt;
   logic             frame_start, right_start;
   logic             rx_bit_en, rx_word_start, rx_end_left, rx_end_right;

   // the transmitter only runs while the receiver is enabled
   assign run = tx_en && rx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_fmt <= FMT_I2S;
         cfg_ws  <= 2'd0;
      end else if (!run) begin
         cfg_fmt <= frame_fmt_e'(fmt_sel);
         cfg_ws  <= width_sel;
      end
   end

   assign ctl   = decode_fmt(cfg_fmt);
   assign wbits = POS_W'(word_bits(cfg_ws));

   aud_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .bclk     (bclk),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt)
   );

   aud_frame_seq #(.SAMPLE_W(SAMPLE_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (run),
      .fall_evt      (fall_evt),
      .rise_evt      (rise_evt),
      .ctl           (ctl),
      .wbits         (wbits),
      .fsync         (fsync),
      .frame_start   (frame_start),
      .right_start   (right_start),
      .rx_bit_en     (rx_bit_en),
      .rx_word_start (rx_word_start),
      .rx_end_left   (rx_end_left),
      .rx_end_right  (rx_end_right)
   );

   aud_tx_shift #(.SAMPLE_W(SAMPLE_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .fall_evt    (fall_evt),
      .frame_start (frame_start),
      .right_start (right_start),
      .wbits       (wbits),
      .smp_valid   (smp_valid),
      .smp_left    (smp_left),
      .smp_right   (smp_right),
      .urun_clr    (urun_clr),
      .smp_ready   (smp_ready),
      .sd          (sd_out),
      .urun        (urun)
   );

   aud_rx_cap #(.SAMPLE_W(SAMPLE_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (rx_bit_en),
      .word_start (rx_word_start),
      .end_left   (rx_end_left),
      .end_right  (rx_end_right),
      .sd_in      (sd_in),
      .rx_left    (rx_left),
      .rx_right   (rx_right),
      .rx_valid   (rx_valid)
   );

   assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run && $past(run) && !$stable(sd_out) |-> $fell(bclk));

   assert_ready_before_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |=> !bclk);

   assert_stopped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (bclk && !sd_out));

endmodule

// File: tb/aud_frame_tx_tb_top.sv
module aud_frame_tx_tb_top;

   localparam int SW   = 32;
   localparam int HALF = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tx_en, rx_en;
   logic [1:0]    fmt_sel, width_sel;
   logic          smp_valid, smp_ready;
   logic [SW-1:0] smp_left, smp_right;
   logic          urun_clr, urun;
   logic          bclk, fsync, sd_out;
   logic [SW-1:0] rx_left, rx_right;
   logic          rx_valid;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;
   bit  uexp    = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   aud_frame_tx #(.SAMPLE_W(SW), .HALF_DIV(HALF)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .rx_en     (rx_en),
      .fmt_sel   (fmt_sel),
      .width_sel (width_sel),
      .smp_valid (smp_valid),
      .smp_ready (smp_ready),
      .smp_left  (smp_left),
      .smp_right (smp_right),
      .urun_clr  (urun_clr),
      .urun      (urun),
      .bclk      (bclk),
      .fsync     (fsync),
      .sd_out    (sd_out),
      .sd_in     (sd_out),
      .rx_left   (rx_left),
      .rx_right  (rx_right),
      .rx_valid  (rx_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int wb(input int ws);
      return (ws == 0) ? 16 : (ws == 1) ? 24 : 32;
   endfunction

   function automatic bit exp_fs(input int fmt, input int w, input int p);
      int  last = 2 * w - 1;
      bit  act;
      case (fmt)
         0:       act = (p == last) || (p < w - 1);
         1:       act = (p < w);
         2:       act = (p == last);
         default: act = (p == 0);
      endcase
      return (fmt == 0) ? !act : act;
   endfunction

   function automatic string fmt_req(input int fmt);
      return (fmt == 0) ? "R3" : (fmt == 1) ? "R4" : (fmt == 2) ? "R5" : "R6";
   endfunction

   task automatic new_stim(input int vprob);
      smp_left  = $urandom;
      smp_right = $urandom;
      smp_valid = (($urandom % 100) < vprob);
   endtask

   task automatic run_case(input int fmt, input int ws, input int nframes,
                           input int vprob, input bit cfg_flip);
      int      w = wb(ws);
      longint  mask = (64'd1 << w) - 1;
      logic [SW-1:0] cl = '0, cr = '0;
      int      bpos = 0;
      bit      first = 1'b1, prevb = 1'b1, prev_ready = 1'b0, pend = 1'b0;
      int      since = 0, frames = 0, cyc = 0;
      bit      eb;
      string   fr;
      tx_en = 1'b0; rx_en = 1'b0;
      fmt_sel = 2'(fmt); width_sel = 2'(ws);
      repeat (3) @(negedge clk);
      chk(bclk == 1'b1, "R10", "idle bclk", bclk, 1);
      chk(fsync == (fmt == 0), "R10", "idle fsync", fsync, (fmt == 0));
      chk(sd_out == 1'b0, "R10", "idle sd_out", sd_out, 0);
      new_stim(vprob);
      rx_en = 1'b1;
      @(negedge clk);
      tx_en = 1'b1;
      fr = cfg_flip ? "R12" : fmt_req(fmt);
      while (frames < nframes && cyc < 20000) begin
         @(negedge clk);
         cyc++; since++;
         if (pend) begin new_stim(vprob); pend = 1'b0; end
         if (cfg_flip && cyc == 40) begin
            fmt_sel = 2'(fmt ^ 1);
            width_sel = (ws == 0) ? 2'd2 : 2'd0;
         end
         if (smp_ready) begin
            chk(!prev_ready, "R7", "ready width", 1, 0);
            if (smp_valid) begin cl = smp_left; cr = smp_right; end
            else begin cl = '0; cr = '0; uexp = 1'b1; end
            pend = 1'b1;
         end
         if (prevb && !bclk) begin
            if (!first) chk(since == 2 * HALF, "R1", "bclk period", since, 2 * HALF);
            since = 0;
            if (first) bpos = 2 * w - 1;
            else bpos = (bpos == 2 * w - 1) ? 0 : bpos + 1;
            if (bpos == 0) chk(prev_ready, "R7", "ready before frame", prev_ready, 1);
            eb = (bpos < w) ? cl[w - 1 - bpos] : cr[2 * w - 1 - bpos];
            chk(sd_out == eb, first ? "R11" : "R2", "sd_out bit", sd_out, eb);
            chk(fsync == exp_fs(fmt, w, bpos), first ? "R11" : fr, "fsync",
                fsync, exp_fs(fmt, w, bpos));
            first = 1'b0;
         end
         if (rx_valid) begin
            chk(longint'(rx_left) == (longint'(cl) & mask), "R9", "rx_left",
                rx_left, longint'(cl) & mask);
            chk(longint'(rx_right) == (longint'(cr) & mask), "R9", "rx_right",
                rx_right, longint'(cr) & mask);
            frames++;
         end
         prev_ready = smp_ready;
         prevb = bclk;
      end
      chk(frames == nframes, "R9", "frames received", frames, nframes);
      fmt_sel = 2'(fmt); width_sel = 2'(ws);
      tx_en = 1'b0;
      @(negedge clk);
      rx_en = 1'b0;
      @(negedge clk);
      chk(bclk == 1'b1 && sd_out == 1'b0, "R10", "stopped", {bclk, sd_out}, 2'b10);
      chk(urun == uexp, "R8", "underrun flag", urun, uexp);
      if (uexp) begin
         urun_clr = 1'b1;
         @(negedge clk);
         urun_clr = 1'b0;
         @(negedge clk);
         chk(urun == 1'b0, "R8", "underrun cleared", urun, 0);
         uexp = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5a17));
      rst_n = 1'b0; tx_en = 1'b0; rx_en = 1'b0;
      fmt_sel = 2'd0; width_sel = 2'd0;
      smp_valid = 1'b0; smp_left = '0; smp_right = '0; urun_clr = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bclk == 1'b1, "R1", "reset bclk", bclk, 1);
      chk(sd_out == 1'b0, "R10", "reset sd_out", sd_out, 0);
      chk(urun == 1'b0, "R8", "reset urun", urun, 0);
      chk(rx_valid == 1'b0 && smp_ready == 1'b0, "R9", "reset strobes",
          {rx_valid, smp_ready}, 0);

      // directed: each format, several widths
      run_case(0, 0, 3, 100, 1'b0);
      run_case(1, 1, 3, 100, 1'b0);
      run_case(2, 2, 3, 100, 1'b0);
      run_case(3, 0, 3, 100, 1'b0);
      run_case(0, 3, 2, 100, 1'b0);
      // directed: no samples at all -> zeros and underrun
      run_case(2, 0, 2, 0, 1'b0);
      // directed: configuration change while running is ignored
      run_case(1, 0, 3, 100, 1'b1);
      run_case(3, 1, 2, 100, 1'b1);
      // random mix
      for (int i = 0; i < 8; i++)
         run_case(int'($urandom % 4), int'($urandom % 4), 2 + int'($urandom % 2), 75, 1'b0);

      // R10: tx enabled alone does not start the engine
      fmt_sel = 2'd1; width_sel = 2'd0;
      tx_en = 1'b1; rx_en = 1'b0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(bclk == 1'b1 && !smp_ready, "R10", "tx without rx", bclk, 1);
      end
      rx_en = 1'b1;
      repeat (40) @(negedge clk);
      rx_en = 1'b0;   // receiver dropped while tx_en still high
      repeat (2) @(negedge clk);
      chk(bclk == 1'b1 && sd_out == 1'b0 && fsync == 1'b0, "R10", "stop by rx_en",
          {bclk, sd_out, fsync}, 3'b100);
      tx_en = 1'b0;
      repeat (2) @(negedge clk);
      if (urun) begin urun_clr = 1'b1; @(negedge clk); urun_clr = 1'b0; end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule